// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a byte-wide flash bus. It samples each write cycle (address plus data byte) and follows multi-cycle command sequences: the two-cycle unlock prefix, a standard program, a chip erase, a sector erase, and an unlock bypass mode. In bypass mode a program needs only a command byte and a data cycle. When a sequence completes, the decoder fires a one-cycle strobe for the operation. The strobe carries the address and data of the final write, which is the target byte for a program or the sector address for a sector erase.

After a strobe the decoder waits in a pending state until the embedded-algorithm engine returns a `done` pulse. It ignores every write while it waits, and also whenever the engine holds `busy` high. The array, the pump timing and the status bits sit outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `read_mode` is 1, `bypass_active` is 0, `op_pending` is 0, and no strobe is high.
- R2: A standard program is the sequence AAh@555h, 55h@2AAh, A0h@555h, then one write with any address and data. In the cycle after that last write is sampled, `prog_stb` is high for exactly one cycle, with `op_addr`/`op_data` equal to that write's address and data.
- R3: A chip erase is the sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h. It produces a one-cycle `chip_erase_stb` with `op_addr`=555h and `op_data`=10h.
- R4: A sector erase has the same five-cycle prefix, followed by data 30h at any address. It produces a one-cycle `sector_erase_stb` with `op_addr` equal to that sixth write's address.
- R5: In standard mode, a write that does not match the next expected cycle returns the decoder to read mode. A later partial sequence then produces no strobe. Command addresses are matched on the low 11 address bits only.
- R6: The sequence AAh@555h, 55h@2AAh, 20h@555h enters bypass mode: `bypass_active` becomes 1 and `read_mode` becomes 0.
- R7: In bypass mode a write of data A0h (any address) followed by one address/data write produces `prog_stb`. After `done`, the decoder stays in bypass mode, so the pair can be repeated.
- R8: In bypass mode, any write other than A0h or 90h is ignored. This includes the unlock and erase bytes: the decoder stays in bypass with no strobe.
- R9: In bypass mode, data 90h followed by data 00h (addresses ignored) leaves bypass and enters read mode. If 90h is followed by any other byte, the decoder stays in bypass. After the exit, a lone A0h/data pair produces no strobe.
- R10: From the strobe until `done`, `op_pending` is 1 and every write is ignored. A write sampled while `busy` is 1 is also ignored.
- R11: A `done` pulse while pending clears `op_pending` on the next cycle. The decoder returns to read mode, or to bypass idle if the operation was a bypass program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | A write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Embedded algorithm running; writes are ignored |
| done | input | 1 | One-cycle pulse: the embedded algorithm has finished |
| prog_stb | output | 1 | Program request strobe |
| chip_erase_stb | output | 1 | Chip erase request strobe |
| sector_erase_stb | output | 1 | Sector erase request strobe |
| op_addr | output | ADDR_W | Address latched with the last strobe |
| op_data | output | 8 | Data latched with the last strobe |
| read_mode | output | 1 | Decoder is idle in array-read mode |
| bypass_active | output | 1 | Unlock bypass mode is in effect |
| op_pending | output | 1 | An operation has been issued and `done` has not arrived |

## Verification
The hardest conditions to reach are the bypass corners: a bypass reset whose second byte is wrong, and a burst of erase-looking bytes inside bypass. Both must leave the mode in place. The stimulus first enters bypass through the three-cycle entry, then interleaves stray unlock and erase bytes and a 90h/01h pair with real bypass programs. It confirms each time that `bypass_active` stays set and that no strobe appears. A complete erase sequence is also written while an operation is pending, and a complete program sequence while `busy` is held, to show that both are dropped rather than replayed.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_U1,
    ST_U2,
    ST_E_SET,
    ST_E_U1,
    ST_E_U2,
    ST_PRG_DATA,
    ST_BP_IDLE,
    ST_BP_PRG,
    ST_BP_RST,
    ST_OP_WAIT
  } fcd_state_e;

  localparam int N_OPS = 3;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_CHIP = 2'd1,
    OP_SECT = 2'd2
  } fcd_op_e;

  typedef struct packed {
    logic unlock1;
    logic unlock2;
    logic std_prog;
    logic bp_enter;
    logic er_setup;
    logic chip_er;
    logic sect_er;
    logic bp_prog;
    logic bp_rst1;
    logic bp_rst2;
  } fcd_match_t;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int CMD_ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output fcd_match_t        hit
);

  localparam logic [CMD_ADDR_W-1:0] A_FIRST  = CMD_ADDR_W'('h555);
  localparam logic [CMD_ADDR_W-1:0] A_SECOND = CMD_ADDR_W'('h2AA);

  logic [CMD_ADDR_W-1:0] key;
  logic at_first;
  logic at_second;

  assign key       = wr_addr[CMD_ADDR_W-1:0];
  assign at_first  = (key == A_FIRST);
  assign at_second = (key == A_SECOND);

  always_comb begin
    hit.unlock1  = at_first  && (wr_data == 8'hAA);
    hit.unlock2  = at_second && (wr_data == 8'h55);
    hit.std_prog = at_first  && (wr_data == 8'hA0);
    hit.bp_enter = at_first  && (wr_data == 8'h20);
    hit.er_setup = at_first  && (wr_data == 8'h80);
    hit.chip_er  = at_first  && (wr_data == 8'h10);
    hit.sect_er  = (wr_data == 8'h30);
    hit.bp_prog  = (wr_data == 8'hA0);
    hit.bp_rst1  = (wr_data == 8'h90);
    hit.bp_rst2  = (wr_data == 8'h00);
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       busy,
  input  logic       done,
  input  fcd_match_t hit,
  output logic       fire,
  output fcd_op_e    fire_op,
  output logic       read_mode,
  output logic       bypass_active,
  output logic       op_pending
);

  fcd_state_e st_q, st_d;
  logic       byp_q, byp_d;
  logic       take;

  assign take = wr_en && !busy;

  always_comb begin
    st_d    = st_q;
    byp_d   = byp_q;
    fire    = 1'b0;
    fire_op = OP_PROG;
    if (st_q == ST_OP_WAIT) begin
      if (done) st_d = byp_q ? ST_BP_IDLE : ST_READ;
    end else if (take) begin
      unique case (st_q)
        ST_READ:     st_d = hit.unlock1 ? ST_U1 : ST_READ;
        ST_U1:       st_d = hit.unlock2 ? ST_U2 : ST_READ;
        ST_U2: begin
          if (hit.std_prog)      st_d = ST_PRG_DATA;
          else if (hit.er_setup) st_d = ST_E_SET;
          else if (hit.bp_enter) begin
            st_d  = ST_BP_IDLE;
            byp_d = 1'b1;
          end else               st_d = ST_READ;
        end
        ST_E_SET:    st_d = hit.unlock1 ? ST_E_U1 : ST_READ;
        ST_E_U1:     st_d = hit.unlock2 ? ST_E_U2 : ST_READ;
        ST_E_U2: begin
          if (hit.chip_er) begin
            st_d    = ST_OP_WAIT;
            fire    = 1'b1;
            fire_op = OP_CHIP;
          end else if (hit.sect_er) begin
            st_d    = ST_OP_WAIT;
            fire    = 1'b1;
            fire_op = OP_SECT;
          end else   st_d = ST_READ;
        end
        ST_PRG_DATA, ST_BP_PRG: begin
          st_d    = ST_OP_WAIT;
          fire    = 1'b1;
          fire_op = OP_PROG;
        end
        ST_BP_IDLE: begin
          if (hit.bp_prog)      st_d = ST_BP_PRG;
          else if (hit.bp_rst1) st_d = ST_BP_RST;
          else                  st_d = ST_BP_IDLE;
        end
        ST_BP_RST: begin
          if (hit.bp_rst2) begin
            st_d  = ST_READ;
            byp_d = 1'b0;
          end else st_d = ST_BP_IDLE;
        end
        default:     st_d = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_READ;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      byp_q <= byp_d;
    end
  end

  assign read_mode     = (st_q == ST_READ);
  assign bypass_active = byp_q;
  assign op_pending    = (st_q == ST_OP_WAIT);

endmodule

// File: rtl/fcd_op_latch.sv
module fcd_op_latch
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  fcd_op_e           fire_op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [N_OPS-1:0]  stb,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data
);

  for (genvar k = 0; k < N_OPS; k++) begin : g_stb
    logic sel;
    assign sel = fire && (fire_op == fcd_op_e'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb[k] <= 1'b0;
      else        stb[k] <= sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_addr <= '0;
      op_data <= '0;
    end else if (fire) begin
      op_addr <= wr_addr;
      op_data <= wr_data;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int CMD_ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              done,
  output logic              prog_stb,
  output logic              chip_erase_stb,
  output logic              sector_erase_stb,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              read_mode,
  output logic              bypass_active,
  output logic              op_pending
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  fcd_match_t       hit;
  logic             fire;
  fcd_op_e          fire_op;
  logic [N_OPS-1:0] stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  fcd_cycle_match #(.ADDR_W(ADDR_W), .CMD_ADDR_W(CMD_ADDR_W)) u_match (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hit     (hit)
  );

  fcd_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .wr_en         (wr_en),
    .busy          (busy),
    .done          (done),
    .hit           (hit),
    .fire          (fire),
    .fire_op       (fire_op),
    .read_mode     (read_mode),
    .bypass_active (bypass_active),
    .op_pending    (op_pending)
  );

  fcd_op_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .fire    (fire),
    .fire_op (fire_op),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .stb     (stb),
    .op_addr (op_addr),
    .op_data (op_data)
  );

  assign prog_stb         = stb[OP_PROG];
  assign chip_erase_stb   = stb[OP_CHIP];
  assign sector_erase_stb = stb[OP_SECT];

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic prog_stb,
  input logic chip_erase_stb,
  input logic sector_erase_stb,
  input logic read_mode,
  input logic bypass_active,
  input logic op_pending
);

  logic any_stb;
  assign any_stb = prog_stb || chip_erase_stb || sector_erase_stb;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, chip_erase_stb, sector_erase_stb})); // R2
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !any_stb); // R2
  AST_STB_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> op_pending); // R10
  AST_PENDING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_pending |=> !any_stb); // R10
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !any_stb); // R10
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pending && done) |=> !op_pending); // R11
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bypass_active && read_mode)); // R6
  AST_BYPASS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_active) |-> read_mode); // R9

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .busy             (busy),
  .done             (done),
  .prog_stb         (prog_stb),
  .chip_erase_stb   (chip_erase_stb),
  .sector_erase_stb (sector_erase_stb),
  .read_mode        (read_mode),
  .bypass_active    (bypass_active),
  .op_pending       (op_pending)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam int AW = 19;

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          busy;
  logic          done;
  logic          prog_stb, chip_erase_stb, sector_erase_stb;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          read_mode, bypass_active, op_pending;

  int   n_chk;
  int   n_fail;
  logic mon_on;
  exp_t sb_q[$];

  flash_cmd_decoder #(.ADDR_W(AW)) dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .busy (busy), .done (done),
    .prog_stb (prog_stb), .chip_erase_stb (chip_erase_stb),
    .sector_erase_stb (sector_erase_stb), .op_addr (op_addr),
    .op_data (op_data), .read_mode (read_mode),
    .bypass_active (bypass_active), .op_pending (op_pending)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d);
    exp_t e;
    e.kind = k; e.addr = a; e.data = d;
    sb_q.push_back(e);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  // Monitor: pops scoreboard on every strobe
  always @(negedge clk) begin
    if (mon_on && (prog_stb || chip_erase_stb || sector_erase_stb)) begin
      logic [1:0] k;
      k = prog_stb ? 2'd0 : (chip_erase_stb ? 2'd1 : 2'd2);
      if (sb_q.size() == 0) begin
        check(1'b0, "R2/R8/R10 unexpected strobe", int'(k), 3);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(k == e.kind && $countones({prog_stb, chip_erase_stb, sector_erase_stb}) == 1,
              "R2/R3/R4/R7 strobe kind", int'(k), int'(e.kind));
        check(op_addr == e.addr, "R2/R4 op_addr", int'(op_addr), int'(e.addr));
        check(op_data == e.data, "R2/R3 op_data", int'(op_data), int'(e.data));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; mon_on = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; busy = 1'b0; done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    check(read_mode && !bypass_active && !op_pending, "R1 reset modes",
          {read_mode, bypass_active, op_pending}, 3'b100);
    check(!(prog_stb || chip_erase_stb || sector_erase_stb), "R1 no strobe",
          {prog_stb, chip_erase_stb, sector_erase_stb}, 0);

    // R2 standard program
    unlock();
    wr(19'h00555, 8'hA0);
    expect_op(2'd0, 19'h12345, 8'h5A);
    wr(19'h12345, 8'h5A);
    check(op_pending, "R10 pending after strobe", op_pending, 1);
    // R10 full erase sequence during pending: ignored
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
    check(op_pending && !read_mode, "R10 still pending", op_pending, 1);
    pulse_done();
    check(read_mode && !op_pending, "R11 done returns to read", read_mode, 1);

    // R3 chip erase
    unlock(); wr(19'h00555, 8'h80); unlock();
    expect_op(2'd1, 19'h00555, 8'h10);
    wr(19'h00555, 8'h10);
    pulse_done();

    // R4 sector erase, upper address bits matter in op_addr
    unlock(); wr(19'h00555, 8'h80); unlock();
    expect_op(2'd2, 19'h40000, 8'h30);
    wr(19'h40000, 8'h30);
    pulse_done();
    check(read_mode, "R11 read after erase", read_mode, 1);

    // R5 mismatch on second cycle, high address bits ignored for matching
    wr(19'h7F555, 8'hAA);
    wr(19'h002AB, 8'h55);
    check(read_mode, "R5 mismatch returns to read", read_mode, 1);
    wr(19'h00555, 8'hA0);
    wr(19'h00100, 8'h33);
    check(read_mode && !op_pending, "R5 partial sequence no op", op_pending, 0);

    // R5 high address bits ignored: unlock with upper bits set works
    wr(19'h7F555, 8'hAA); wr(19'h3C2AA, 8'h55); wr(19'h01555, 8'hA0);
    expect_op(2'd0, 19'h00077, 8'hC3);
    wr(19'h00077, 8'hC3);
    pulse_done();

    // R10 busy: writes ignored
    @(negedge clk); busy = 1'b1;
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00200, 8'h11);
    @(negedge clk); busy = 1'b0;
    check(read_mode && !op_pending, "R10 busy ignores writes", op_pending, 0);

    // R6 bypass entry
    unlock(); wr(19'h00555, 8'h20);
    check(bypass_active && !read_mode, "R6 bypass entered", bypass_active, 1);

    // R7 bypass programs
    wr(19'h00000, 8'hA0);
    expect_op(2'd0, 19'h00010, 8'h01);
    wr(19'h00010, 8'h01);
    pulse_done();
    check(bypass_active && !read_mode && !op_pending, "R7 stays bypass", bypass_active, 1);
    wr(19'h55555, 8'hA0);
    expect_op(2'd0, 19'h7FFFF, 8'hFE);
    wr(19'h7FFFF, 8'hFE);
    pulse_done();

    // R8 other writes ignored in bypass
    unlock(); wr(19'h00555, 8'h80); wr(19'h00555, 8'h10); wr(19'h00555, 8'h30);
    check(bypass_active && !op_pending, "R8 stray bytes ignored", bypass_active, 1);

    // R9 bad reset second byte keeps bypass
    wr(19'h00000, 8'h90); wr(19'h00000, 8'h01);
    check(bypass_active && !read_mode, "R9 bad reset stays bypass", bypass_active, 1);
    wr(19'h00123, 8'hA0);
    expect_op(2'd0, 19'h00124, 8'h77);
    wr(19'h00124, 8'h77);
    pulse_done();

    // R9 exit
    wr(19'h7FFFF, 8'h90); wr(19'h00012, 8'h00);
    check(read_mode && !bypass_active, "R9 exit to read", read_mode, 1);
    wr(19'h00000, 8'hA0); wr(19'h00300, 8'h44);
    check(read_mode && !op_pending, "R9 no bypass program after exit", op_pending, 0);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 all expected strobes seen", sb_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule